// File: doc/BRIEF.md
# Presettable Synchronous Cascadable Counter

This block is a binary up-counter built from 4-bit stages, with every state change taken on the rising clock edge. Each stage has a synchronous clear, a synchronous parallel load, two count enables and a terminal-count carry. The clear and the load are active low. The two enables are a shared parallel enable and a per-stage trickle enable. When the clear and the load are both released, a stage advances by one only if both of its enables are high. In every other case it keeps its value.

The top module chains `STAGES` such stages. The trickle enable of stage 0 is the external trickle enable. Each higher stage takes its trickle enable from the carry of the stage below it, so the chain counts as one wide synchronous binary counter and needs no extra gating.

A modulo-N count is made outside the block. The user decodes the wanted last value from the outputs and drives the clear input low on that value.

Top module: `cnt_chain`

## Requirements
- R1: The stored count changes only at a rising clock edge. A change on clear, load, the enables or the data between edges leaves the outputs unchanged until the next rising edge.
- R2: If `clr_n` is low at a rising edge, every bit of `q` is 0 after that edge. This holds whatever the levels of `load_n`, `enp`, `ent` and `din`.
- R3: If `clr_n` is high and `load_n` is low at a rising edge, `q` equals `din` after that edge, whatever the enable levels. Stage i loads `din[4i+3:4i]`, and any value can be loaded.
- R4: If `clr_n` and `load_n` are both high, a stage increments only when `enp` and its own trickle enable are both high. Otherwise it holds.
- R5: The carry of a stage is high exactly while that stage holds 15 and its trickle enable is high. `enp` has no effect on it.
- R6: Stage i (i > 0) takes its trickle enable from the carry of stage i-1. With `enp` and `ent` high, the whole of `q` therefore counts modulo 2^(4·STAGES). `carry_out` is high exactly while `q` is all ones and `ent` is high.
- R7: Driving `clr_n` low whenever `q` equals a value V gives a repeating count 0, 1, …, V, 0.
- R8: Clear takes priority over load, and load takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| enp | input | 1 | Parallel count enable, shared by all stages |
| ent | input | 1 | Trickle count enable into stage 0 |
| din | input | 4·STAGES | Parallel load value |
| q | output | 4·STAGES | Current count |
| stage_carry | output | STAGES | Terminal-count carry of each stage |
| carry_out | output | 1 | Carry of the top stage |

## Verification
The hardest case to reach is the carry of the top stage. With the default two stages, it is high only after a 255-step run in which the low stage's carry has enabled the high stage at every nibble boundary. The bench reaches it in two ways. It loads all ones directly. It also clears the counter and counts through the full 256-cycle wrap against its own model, checking `q`, `carry_out` and the low-stage carry on every cycle. The clear-feedback modulo count is closed through the bench. The bench decodes the observed count and drives `clr_n` before each edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  localparam int NIB = 4;

  typedef enum logic [1:0] {
    M_HOLD  = 2'd0,
    M_INC   = 2'd1,
    M_LOAD  = 2'd2,
    M_CLEAR = 2'd3
  } mode_e;

  // Priority: clear, then load, then count, else hold.
  function automatic mode_e pick_mode(input logic clr_n, input logic load_n,
                                      input logic enp, input logic ent);
    if (!clr_n)            return M_CLEAR;
    else if (!load_n)      return M_LOAD;
    else if (enp && ent)   return M_INC;
    else                   return M_HOLD;
  endfunction

  function automatic logic [NIB-1:0] step(input mode_e m,
                                          input logic [NIB-1:0] cur,
                                          input logic [NIB-1:0] din);
    case (m)
      M_CLEAR: return '0;
      M_LOAD:  return din;
      M_INC:   return cur + 1'b1;
      default: return cur;
    endcase
  endfunction

  function automatic logic at_terminal(input logic [NIB-1:0] v);
    return &v;
  endfunction

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic  clr_n,
  input  logic  load_n,
  input  logic  enp,
  input  logic  ent,
  output mode_e mode
);

  always_comb mode = pick_mode(clr_n, load_n, enp, ent);

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
(
  input  logic           clk,
  input  logic           clr_n,
  input  logic           load_n,
  input  logic           enp,
  input  logic           ent,
  input  logic [NIB-1:0] din,
  output logic [NIB-1:0] q,
  output logic           carry
);

  mode_e          mode;
  logic [NIB-1:0] q_r;
  logic           term_hit;

  cnt_ctrl u_ctrl (
    .clr_n  (clr_n),
    .load_n (load_n),
    .enp    (enp),
    .ent    (ent),
    .mode   (mode)
  );

  always_ff @(posedge clk) q_r <= step(mode, q_r, din);

  // Terminal value seen, exposed for the carry and its checks.
  assign term_hit = at_terminal(q_r);
  assign carry    = term_hit & ent;
  assign q        = q_r;

  // R2: clear wins over everything.
  a_r2_clear: assert property (@(posedge clk) disable iff ($isunknown(q_r))
    !clr_n |=> q_r == '0);
  // R3 and R8: load wins over counting.
  a_r3_load: assert property (@(posedge clk) disable iff ($isunknown(q_r))
    (clr_n && !load_n) |=> q_r == $past(din));
  // R4: count only when both enables are high.
  a_r4_count: assert property (@(posedge clk) disable iff ($isunknown(q_r))
    (clr_n && load_n && enp && ent) |=> q_r == $past(q_r) + 1'b1);
  a_r4_hold: assert property (@(posedge clk) disable iff ($isunknown(q_r))
    (clr_n && load_n && !(enp && ent)) |=> $stable(q_r));
  // R5: carry only at fifteen with trickle enable.
  a_r5_carry: assert property (@(posedge clk) disable iff ($isunknown(q_r))
    carry |-> (ent && q_r == 4'hF));

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int STAGES = 2,
  localparam int W = NIB * STAGES
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              enp,
  input  logic              ent,
  input  logic [W-1:0]      din,
  output logic [W-1:0]      q,
  output logic [STAGES-1:0] stage_carry,
  output logic              carry_out
);

  logic [STAGES-1:0] trickle;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign trickle[i] = ent;
    end else begin : g_next
      assign trickle[i] = stage_carry[i-1];
    end

    cnt_stage u_stage (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .enp    (enp),
      .ent    (trickle[i]),
      .din    (din[NIB*i +: NIB]),
      .q      (q[NIB*i +: NIB]),
      .carry  (stage_carry[i])
    );
  end

  assign carry_out = stage_carry[STAGES-1];

  // R6: the chain as a whole counts in binary.
  a_r6_chain_inc: assert property (@(posedge clk) disable iff ($isunknown(q))
    (clr_n && load_n && enp && ent) |=> q == $past(q) + 1'b1);
  a_r6_carry_top: assert property (@(posedge clk) disable iff ($isunknown(q))
    carry_out |-> (&q && ent));

endmodule

// File: tb/sim_cnt_chain.sv
module sim_cnt_chain;

  localparam int ST = 2;
  localparam int W  = 4 * ST;

  logic          clk = 1'b0;
  logic          clr_n, load_n, enp, ent;
  logic [W-1:0]  din;
  logic [W-1:0]  q;
  logic [ST-1:0] stage_carry;
  logic          carry_out;

  int n_vec  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cnt_chain #(.STAGES(ST)) u0 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .enp(enp), .ent(ent),
    .din(din), .q(q), .stage_carry(stage_carry), .carry_out(carry_out)
  );

  // {clr_n, load_n, enp, ent, din[7:0], exp_q[7:0], exp_carry_out, exp_carry0}
  localparam logic [21:0] TBL [0:14] = '{
    {1'b0,1'b0,1'b1,1'b1,8'h55,8'h00,1'b0,1'b0},   // clear beats load (R2 R8)
    {1'b1,1'b0,1'b0,1'b0,8'h0C,8'h0C,1'b0,1'b0},   // preset twelve (R3)
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h0D,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h0E,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h0F,1'b0,1'b1},   // low carry (R5)
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h10,1'b0,1'b0},   // nibble wrap (R6)
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h11,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h12,1'b0,1'b0},
    {1'b1,1'b1,1'b0,1'b1,8'h00,8'h12,1'b0,1'b0},   // inhibit, enp low (R4)
    {1'b1,1'b1,1'b1,1'b0,8'h00,8'h12,1'b0,1'b0},   // inhibit, ent low (R4)
    {1'b1,1'b0,1'b0,1'b1,8'h0F,8'h0F,1'b0,1'b1},   // carry ignores enp (R5)
    {1'b1,1'b1,1'b0,1'b0,8'h00,8'h0F,1'b0,1'b0},   // ent gates carry (R5)
    {1'b1,1'b0,1'b1,1'b1,8'hA3,8'hA3,1'b0,1'b0},   // load beats count (R8)
    {1'b1,1'b0,1'b1,1'b1,8'hFF,8'hFF,1'b1,1'b1},   // top carry (R6)
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h00,1'b0,1'b0}    // full wrap (R6)
  };

  task automatic check(input string tag, input logic [W-1:0] aq, input logic [W-1:0] eq);
    n_vec++;
    if (aq !== eq) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, aq, eq);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic p, input logic t,
                       input logic [W-1:0] d);
    clr_n = c; load_n = l; enp = p; ent = t; din = d;
  endtask

  task automatic finish_up();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin : main
    logic [W-1:0] exp_q;
    drive(1'b1, 1'b1, 1'b0, 1'b0, '0);
    @(negedge clk);

    // Table walk: inputs at a falling edge, results read 5 ns after the rise.
    for (int i = 0; i < 15; i++) begin
      drive(TBL[i][21], TBL[i][20], TBL[i][19], TBL[i][18], TBL[i][17:10]);
      @(posedge clk); #5;
      check($sformatf("R2/R3/R4/R6/R8 vector %0d q", i), q, TBL[i][9:2]);
      check($sformatf("R5/R6 vector %0d carry_out", i), {7'd0, carry_out}, {7'd0, TBL[i][1]});
      check($sformatf("R5 vector %0d stage0 carry", i), {7'd0, stage_carry[0]}, {7'd0, TBL[i][0]});
      @(negedge clk);
    end

    // R1: input changes between edges do not move q.
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'h37);
    @(posedge clk); #5;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'hC8);
    #3;
    check("R1 q held between edges", q, 8'h37);
    @(posedge clk); #5;
    check("R1 R2 clear at next edge", q, 8'h00);
    @(negedge clk);

    // R6: full 8-bit wrap against a bench model.
    exp_q = '0;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    for (int k = 0; k < 256; k++) begin
      @(posedge clk); #5;
      exp_q = exp_q + 8'd1;
      check("R6 wrap q", q, exp_q);
      check("R6 wrap carry_out", {7'd0, carry_out}, {7'd0, exp_q == 8'hFF});
      check("R5 wrap stage0 carry", {7'd0, stage_carry[0]}, {7'd0, exp_q[3:0] == 4'hF});
      @(negedge clk);
    end

    // R7: modulo-10 count by decoding nine onto the clear input.
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    @(posedge clk); #5;
    @(negedge clk);
    exp_q = '0;
    for (int k = 0; k < 22; k++) begin
      drive(q != 8'd9, 1'b1, 1'b1, 1'b1, 8'h00);
      @(posedge clk); #5;
      exp_q = (exp_q == 8'd9) ? 8'd0 : exp_q + 8'd1;
      check("R7 modulo count", q, exp_q);
      @(negedge clk);
    end

    // R8: clear over load with enables low.
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'hEE);
    @(posedge clk); #5;
    check("R8 clear over load", q, 8'h00);
    @(negedge clk);

    finish_up();
  end

endmodule